// File: doc/BRIEF.md
# Indirect CSR Mailbox Bridge

The bridge lets a host reach a private register space through a small 64-bit CSR window. The private space uses a 16-bit address and 32-bit data. The host never touches that space directly. To write, it places the value in the upper half of a data register and then posts a command that names the target address. To read, it posts a read command, waits for the acknowledge, and then collects the value from the lower half of the same data register.

Every transaction ends with a two-phase handshake. The acknowledge bit rises once the private bus has answered. It stays high until the host writes the command register with only that bit set. Only after the host sees the bit read back as 0 is the mailbox free for the next command.

Beside the mailbox the window holds two plain registers: a three-bit port selector, which drives an output to the datapath, and a 64-bit scratch register the host can use freely. On the private side the block acts as a bus master. It raises a request with valid/ready and then waits for a separate response strobe.

Top module: `csr_mailbox_bridge`

## Requirements
- R1: After reset the command, data, port-select and scratch registers all read 0, no private request is raised, and the port-select output is 0.
- R2: A write to the command register at byte offset 0x30 that has bit 1 set and bit 0 clear starts one private write. The private address is taken from bits 47:32 and the data from bits 63:32 of the data register at offset 0x38. The request stays valid, with stable address, data and direction, until ready is high.
- R3: A command with bit 0 set and bit 1 clear starts one private read. Once the acknowledge reads 1, bits 31:0 of the data register hold the response data. Host writes never change those bits; they only load bits 63:32.
- R4: The acknowledge (bit 2 of the command register) becomes 1 in the cycle after the response strobe. It then stays 1, whatever other command writes arrive, until it is cleared.
- R5: A command-register write with bit 2 set clears a set acknowledge, which then reads 0. A later command is accepted normally.
- R6: A command written while a transaction is outstanding or its acknowledge is still set is ignored: no private request follows from it.
- R7: A command with both bit 0 and bit 1 set is dropped. No private request is made and the acknowledge stays 0.
- R8: The port-select register at offset 0x40 keeps written bits 2:0 and drives them on the port-select output. Its other bits read 0.
- R9: The scratch register at offset 0x48 stores and returns all 64 written bits.
- R10: Read data appears, with a valid strobe, in the cycle after a host read strobe. Offsets outside the four registers read 0. Reading the command register returns the acknowledge in bit 2, the pending read and write flags in bits 0 and 1, and the last accepted address in bits 47:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| port_sel | output | 3 | Selected port |
| ib_req_valid | output | 1 | Private request valid |
| ib_req_ready | input | 1 | Private request accepted |
| ib_req_write | output | 1 | Request is a write |
| ib_req_addr | output | 16 | Private address |
| ib_req_wdata | output | 32 | Private write data |
| ib_rsp_valid | input | 1 | Private response strobe |
| ib_rsp_rdata | input | 32 | Private response data |

## Verification
A host read result is due one cycle after its strobe. The bench raises the strobe for a single edge and samples at the falling edge that follows. A private request starts the cycle after its command write and can be held for several cycles by a responder that stalls ready at random. The acknowledge rises one cycle after the response strobe. So the bench does not count cycles for the mailbox: it polls the command register until the acknowledge appears. A monitor compares every request handshake at the clock edge against a queue of expected items, and any handshake with no expected item is counted as a failure.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int HOST_AW = 8;
  localparam logic [HOST_AW-1:0] OFS_CMD   = 8'h30;
  localparam logic [HOST_AW-1:0] OFS_DATA  = 8'h38;
  localparam logic [HOST_AW-1:0] OFS_PSEL  = 8'h40;
  localparam logic [HOST_AW-1:0] OFS_SCRCH = 8'h48;

  localparam int CMD_RD_BIT  = 0;
  localparam int CMD_WR_BIT  = 1;
  localparam int CMD_ACK_BIT = 2;
  localparam int CMD_ADDR_LO = 32;

  typedef enum logic [1:0] {
    MBX_IDLE = 2'd0,
    MBX_REQ  = 2'd1,
    MBX_WAIT = 2'd2
  } mbx_state_e;
endpackage

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
  import mbx_pkg::*;
#(
  parameter int IB_AW = 16,
  parameter int IB_DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_strobe,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_ack,
  input  logic [IB_AW-1:0] cmd_addr,
  input  logic [IB_DW-1:0] cmd_wdata,
  output logic             ack,
  output logic             pend_rd,
  output logic             pend_wr,
  output logic [IB_AW-1:0] last_addr,
  output logic [IB_DW-1:0] rd_result,
  output logic             ib_req_valid,
  input  logic             ib_req_ready,
  output logic             ib_req_write,
  output logic [IB_AW-1:0] ib_req_addr,
  output logic [IB_DW-1:0] ib_req_wdata,
  input  logic             ib_rsp_valid,
  input  logic [IB_DW-1:0] ib_rsp_rdata
);
  mbx_state_e       state_q, state_d;
  logic             ack_q, ack_d;
  logic             dir_wr_q;
  logic [IB_AW-1:0] addr_q;
  logic [IB_DW-1:0] wdat_q;
  logic [IB_DW-1:0] rdat_q;
  logic             accept, clear_ack, rsp_take, rdat_en;

  assign accept    = cmd_strobe && !cmd_ack && (state_q == MBX_IDLE) && !ack_q &&
                     (cmd_rd ^ cmd_wr);
  assign clear_ack = cmd_strobe && cmd_ack && ack_q;
  assign rsp_take  = (state_q == MBX_WAIT) && ib_rsp_valid;
  assign rdat_en   = rsp_take && !dir_wr_q;

  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    case (state_q)
      MBX_IDLE: if (accept) state_d = MBX_REQ;
      MBX_REQ:  if (ib_req_ready) state_d = MBX_WAIT;
      MBX_WAIT: if (ib_rsp_valid) begin
        state_d = MBX_IDLE;
        ack_d   = 1'b1;
      end
      default:  state_d = MBX_IDLE;
    endcase
    if (clear_ack) ack_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MBX_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_wr_q <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
    end else if (accept) begin
      dir_wr_q <= cmd_wr;
      addr_q   <= cmd_addr;
      wdat_q   <= cmd_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (rdat_en) rdat_q <= ib_rsp_rdata;
  end

  assign ack          = ack_q;
  assign pend_rd      = (state_q != MBX_IDLE) && !dir_wr_q;
  assign pend_wr      = (state_q != MBX_IDLE) && dir_wr_q;
  assign last_addr    = addr_q;
  assign rd_result    = rdat_q;
  assign ib_req_valid = (state_q == MBX_REQ);
  assign ib_req_write = dir_wr_q;
  assign ib_req_addr  = addr_q;
  assign ib_req_wdata = wdat_q;

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    ib_req_valid && !ib_req_ready |=> ib_req_valid && $stable(ib_req_addr) &&
    $stable(ib_req_wdata) && $stable(ib_req_write));
  a_r4_ack_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MBX_WAIT) && ib_rsp_valid |=> ack);
  a_r4_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !(cmd_strobe && cmd_ack) |=> ack);
  a_r5_ack_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ack && cmd_strobe && cmd_ack |=> !ack);
  a_r6_no_req_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ib_req_valid);
  a_r7_illegal_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe && cmd_rd && cmd_wr && !ib_req_valid |=> !ib_req_valid);
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs
  import mbx_pkg::*;
#(
  parameter int IB_AW     = 16,
  parameter int IB_DW     = 32,
  parameter int NUM_PORTS = 8,
  localparam int PSW      = $clog2(NUM_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               host_rvalid,
  output logic [PSW-1:0]     port_sel,
  output logic               cmd_strobe,
  output logic               cmd_rd,
  output logic               cmd_wr,
  output logic               cmd_ack,
  output logic [IB_AW-1:0]   cmd_addr,
  output logic [IB_DW-1:0]   cmd_wdata,
  input  logic               ack,
  input  logic               pend_rd,
  input  logic               pend_wr,
  input  logic [IB_AW-1:0]   last_addr,
  input  logic [IB_DW-1:0]   rd_result
);
  logic [IB_DW-1:0] wr_hold_q;
  logic [PSW-1:0]   psel_q;
  logic [63:0]      scr_q;
  logic [63:0]      rdata_q, rdata_d;
  logic             rvalid_q;
  logic             wr_data_en, wr_psel_en, wr_scr_en;

  assign wr_data_en = host_wr_en && (host_addr == OFS_DATA);
  assign wr_psel_en = host_wr_en && (host_addr == OFS_PSEL);
  assign wr_scr_en  = host_wr_en && (host_addr == OFS_SCRCH);
  assign cmd_strobe = host_wr_en && (host_addr == OFS_CMD);
  assign cmd_rd     = host_wdata[CMD_RD_BIT];
  assign cmd_wr     = host_wdata[CMD_WR_BIT];
  assign cmd_ack    = host_wdata[CMD_ACK_BIT];
  assign cmd_addr   = host_wdata[CMD_ADDR_LO +: IB_AW];
  assign cmd_wdata  = wr_hold_q;

  always_comb begin
    rdata_d = '0;
    case (host_addr)
      OFS_CMD: begin
        rdata_d[CMD_RD_BIT]               = pend_rd;
        rdata_d[CMD_WR_BIT]               = pend_wr;
        rdata_d[CMD_ACK_BIT]              = ack;
        rdata_d[CMD_ADDR_LO +: IB_AW]     = last_addr;
      end
      OFS_DATA: begin
        rdata_d[IB_DW-1:0]    = rd_result;
        rdata_d[32 +: IB_DW]  = wr_hold_q;
      end
      OFS_PSEL:  rdata_d[PSW-1:0] = psel_q;
      OFS_SCRCH: rdata_d = scr_q;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wr_hold_q <= '0;
    else if (wr_data_en) wr_hold_q <= host_wdata[32 +: IB_DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          psel_q <= '0;
    else if (wr_psel_en) psel_q <= host_wdata[PSW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         scr_q <= '0;
    else if (wr_scr_en) scr_q <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_rd_en;
      if (host_rd_en) rdata_q <= rdata_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign port_sel    = psel_q;

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rvalid);
  a_r8_psel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_psel_en |=> $stable(port_sel));
  a_r3_low_half_host_proof: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> $stable(rd_result));
endmodule

// File: rtl/csr_mailbox_bridge.sv
module csr_mailbox_bridge
  import mbx_pkg::*;
#(
  parameter int IB_AW     = 16,
  parameter int IB_DW     = 32,
  parameter int NUM_PORTS = 8,
  localparam int PSW      = $clog2(NUM_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_rd_en,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic               host_rvalid,
  output logic [PSW-1:0]     port_sel,
  output logic               ib_req_valid,
  input  logic               ib_req_ready,
  output logic               ib_req_write,
  output logic [IB_AW-1:0]   ib_req_addr,
  output logic [IB_DW-1:0]   ib_req_wdata,
  input  logic               ib_rsp_valid,
  input  logic [IB_DW-1:0]   ib_rsp_rdata
);
  logic             cmd_strobe, cmd_rd, cmd_wr, cmd_ack;
  logic [IB_AW-1:0] cmd_addr, last_addr;
  logic [IB_DW-1:0] cmd_wdata, rd_result;
  logic             ack, pend_rd, pend_wr;

  mbx_host_regs #(.IB_AW(IB_AW), .IB_DW(IB_DW), .NUM_PORTS(NUM_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .port_sel(port_sel),
    .cmd_strobe(cmd_strobe), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_ack(cmd_ack),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ack(ack), .pend_rd(pend_rd), .pend_wr(pend_wr),
    .last_addr(last_addr), .rd_result(rd_result)
  );

  mbx_sequencer #(.IB_AW(IB_AW), .IB_DW(IB_DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_strobe(cmd_strobe), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_ack(cmd_ack),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ack(ack), .pend_rd(pend_rd), .pend_wr(pend_wr),
    .last_addr(last_addr), .rd_result(rd_result),
    .ib_req_valid(ib_req_valid), .ib_req_ready(ib_req_ready),
    .ib_req_write(ib_req_write), .ib_req_addr(ib_req_addr),
    .ib_req_wdata(ib_req_wdata), .ib_rsp_valid(ib_rsp_valid),
    .ib_rsp_rdata(ib_rsp_rdata)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ib_req_valid);
endmodule

// File: tb/csr_mailbox_bridge_tb_top.sv
`timescale 1ns/1ps
module csr_mailbox_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        host_rvalid;
  logic [2:0]  port_sel;
  logic        ib_req_valid, ib_req_ready, ib_req_write;
  logic [15:0] ib_req_addr;
  logic [31:0] ib_req_wdata;
  logic        ib_rsp_valid;
  logic [31:0] ib_rsp_rdata;
  logic        hold_ready = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_mailbox_bridge dut_i (.*);

  // private-space model: 16 words, stalling ready, 1..2 cycle response
  logic [7:0]  lfsr;
  logic [31:0] mem [16];
  logic [1:0]  rsp_cnt;
  logic        p_wr;
  logic [3:0]  p_addr;
  logic [31:0] p_data;
  assign ib_req_ready = !hold_ready && (lfsr[1:0] != 2'b00);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 8'h5A; rsp_cnt <= 0; ib_rsp_valid <= 0; ib_rsp_rdata <= 0;
      p_wr <= 0; p_addr <= 0; p_data <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 + i;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ib_rsp_valid <= 1'b0;
      if (ib_req_valid && ib_req_ready) begin
        rsp_cnt <= 2'd1 + {1'b0, lfsr[2]};
        p_wr <= ib_req_write; p_addr <= ib_req_addr[3:0]; p_data <= ib_req_wdata;
      end else if (rsp_cnt != 0) begin
        rsp_cnt <= rsp_cnt - 1;
        if (rsp_cnt == 1) begin
          ib_rsp_valid <= 1'b1;
          ib_rsp_rdata <= p_wr ? 32'h0 : mem[p_addr];
          if (p_wr) mem[p_addr] <= p_data;
        end
      end
    end
  end

  // scoreboard: expected private requests {write, addr, data}
  typedef struct packed { logic wr; logic [15:0] addr; logic [31:0] data; } req_t;
  req_t exp_q[$];

  always @(posedge clk) begin
    if (rst_n && ib_req_valid && ib_req_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R6/R7 unexpected request act wr=%0b addr=%h data=%h exp none",
                 ib_req_write, ib_req_addr, ib_req_wdata);
      end else begin
        req_t e;
        e = exp_q.pop_front();
        if (ib_req_write !== e.wr || ib_req_addr !== e.addr ||
            (e.wr && ib_req_wdata !== e.data)) begin
          failures++;
          $display("FAIL R2/R3 request act wr=%0b addr=%h data=%h exp wr=%0b addr=%h data=%h",
                   ib_req_write, ib_req_addr, ib_req_wdata, e.wr, e.addr, e.data);
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    checks++;
    if (host_rvalid !== 1'b1) begin
      failures++;
      $display("FAIL R10 rvalid act=%0b exp=1", host_rvalid);
    end
    d = host_rdata;
  endtask

  task automatic wait_ack();
    logic [63:0] v;
    for (int n = 0; n < 60; n++) begin
      hread(8'h30, v);
      if (v[2]) return;
    end
    failures++;
    $display("FAIL R4 ack act=0 exp=1");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 req_valid", {63'b0, ib_req_valid}, 64'h0);
    check("R1 port_sel", {61'b0, port_sel}, 64'h0);
    hread(8'h30, v); check("R1 cmd", v, 64'h0);
    hread(8'h38, v); check("R1 data", v, 64'h0);
    hread(8'h48, v); check("R1 scratch", v, 64'h0);
    // R9 scratch, R10 unmapped
    hwrite(8'h48, 64'hDEAD_BEEF_0123_4567);
    hread(8'h48, v); check("R9 scratch", v, 64'hDEAD_BEEF_0123_4567);
    hread(8'h50, v); check("R10 unmapped", v, 64'h0);
    // R8 port select
    hwrite(8'h40, 64'hFFFF_FFFF_FFFF_FFFD);
    hread(8'h40, v); check("R8 psel reg", v, 64'h5);
    check("R8 psel port", {61'b0, port_sel}, 64'h5);
    // R2 write; low half of data write ignored (R3)
    hwrite(8'h38, 64'hA5A5_0001_0000_FFFF);
    hread(8'h38, v); check("R3 data low kept", v, 64'hA5A5_0001_0000_0000);
    exp_q.push_back({1'b1, 16'h0003, 32'hA5A5_0001});
    hwrite(8'h30, {16'h0, 16'h0003, 32'h2});
    wait_ack();
    hread(8'h30, v); check("R10 cmd after write", v, {16'h0, 16'h0003, 32'h4});
    // R6: command while ack set is ignored; R4 ack stays set
    hwrite(8'h30, {16'h0, 16'h0005, 32'h2});
    repeat (6) @(negedge clk);
    hread(8'h30, v); check("R4 ack held", {63'b0, v[2]}, 64'h1);
    // R5 clear
    hwrite(8'h30, 64'h4);
    hread(8'h30, v); check("R5 ack cleared", {63'b0, v[2]}, 64'h0);
    // R3 read back written word
    exp_q.push_back({1'b0, 16'h0003, 32'h0});
    hwrite(8'h30, {16'h0, 16'h0003, 32'h1});
    wait_ack();
    hread(8'h38, v); check("R3 read data", v, 64'hA5A5_0001_A5A5_0001);
    hwrite(8'h30, 64'h4);
    // R6 address 5 untouched
    exp_q.push_back({1'b0, 16'h0005, 32'h0});
    hwrite(8'h30, {16'h0, 16'h0005, 32'h1});
    wait_ack();
    hread(8'h38, v); check("R6 addr5 untouched", {32'h0, v[31:0]}, 64'h1000_0005);
    hwrite(8'h30, 64'h4);
    // R7 both bits
    hwrite(8'h30, {16'h0, 16'h0007, 32'h3});
    repeat (12) @(negedge clk);
    hread(8'h30, v); check("R7 dropped", {61'b0, v[2:0]}, 64'h0);
    // R6 command while pending (ready stalled)
    hold_ready = 1'b1;
    hwrite(8'h38, 64'h1234_5678_0000_0000);
    exp_q.push_back({1'b1, 16'h0009, 32'h1234_5678});
    hwrite(8'h30, {16'h0, 16'h0009, 32'h2});
    hread(8'h30, v); check("R10 pending wr flag", {61'b0, v[2:0]}, 64'h2);
    hwrite(8'h30, {16'h0, 16'h000A, 32'h1});
    repeat (3) @(negedge clk);
    hold_ready = 1'b0;
    wait_ack();
    hread(8'h30, v); check("R6 addr kept", {48'h0, v[47:32]}, 64'h9);
    hwrite(8'h30, 64'h4);
    // R2 verify memory via read
    exp_q.push_back({1'b0, 16'h0009, 32'h0});
    hwrite(8'h30, {16'h0, 16'h0009, 32'h1});
    wait_ack();
    hread(8'h38, v); check("R2 word stored", {32'h0, v[31:0]}, 64'h1234_5678);
    hwrite(8'h30, 64'h4);
    repeat (10) @(negedge clk);
    check("R6 queue drained", exp_q.size(), 64'h0);
    finish_run();
  end
endmodule